// File: doc/BRIEF.md
# Signed Adder with Separate Overflow and Underflow Flags

This block adds two two's-complement operands of a configurable width and returns a sum of that same width. Both operands are widened by one bit, by repeating their sign bit, before the addition. The extra top bit of the widened sum is compared with the sign bit of the truncated result. That comparison raises one of two flags. The positive flag fires when the true sum is above the largest representable value. The negative flag fires when the true sum is below the smallest representable value.

The block is purely combinational and has no clock or reset. A surrounding datapath can use the two flags to pick a clamp direction, or to tell a positive wrap from a negative one without looking at the operands again. A parameter selects how the widened addition is built: either with the language's add operator, or with an explicit ripple-carry chain of full adders. Both forms give identical outputs.

Top module: `signed_ovf_adder`

## Requirements
- R1: `result` equals the true signed sum `a + b` reduced modulo 2^WIDTH, which is the low WIDTH bits of the sum.
- R2: `overflow` is 1 exactly when the true signed sum is greater than 2^(WIDTH-1)-1. This is the case where the extra bit of the widened sum is 0 and bit WIDTH-1 of `result` is 1.
- R3: `underflow` is 1 exactly when the true signed sum is less than -2^(WIDTH-1). This is the case where the extra bit is 1 and bit WIDTH-1 of `result` is 0.
- R4: `overflow` and `underflow` are never 1 at the same time.
- R5: With WIDTH=4, adding 4'b0111 (+7) and 4'b0001 (+1) gives `result`=4'b1000, `overflow`=1 and `underflow`=0.
- R6: With WIDTH=4, adding 4'b1000 (-8) and 4'b1111 (-1) gives `result`=4'b0111, `underflow`=1 and `overflow`=0.
- R7: With WIDTH=4, 3+3 gives 4'b0110 (+6) and -3+-3 gives 4'b1010 (-6), with both flags 0 in each case.
- R8: When the sign bits of `a` and `b` differ, both flags are 0.
- R9: The outputs follow the inputs with no clock edge. WIDTH defaults to 4, and a WIDTH below 2 stops elaboration.
- R10: The parameter ARCH selects the add operator (0) or an explicit ripple-carry chain (1). Both give the outputs of R1 to R3 at any width, including WIDTH=8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | WIDTH | First two's-complement operand |
| b | input | WIDTH | Second two's-complement operand |
| result | output | WIDTH | Sum, wrapped to WIDTH bits |
| overflow | output | 1 | True sum exceeded the largest positive value |
| underflow | output | 1 | True sum fell below the most negative value |

## Verification
At WIDTH=4, every one of the 256 operand pairs is applied. This covers both wrap directions, the exact edges where a sum just fits or just misses, and every mixed-sign pair. Mixed-sign pairs must never raise a flag, so they separate a correct sign-bit comparison from one that looks only at the carry.

The named corner sums +7+1, -8+-1, 3+3 and -3+-3 are applied directly. They confirm the expected bit patterns and tell the positive flag apart from the negative one.

A ripple-carry instance at WIDTH=8 receives seeded random pairs plus the extreme pairs. This shows that the two build variants agree and that nothing depends on the default width. One further check changes the inputs between clock edges, which shows that the outputs need no clock.

// File: rtl/sox_pkg.sv
package sox_pkg;

   // Build variants for the widened addition
   localparam int SOX_ARCH_OPERATOR = 0;
   localparam int SOX_ARCH_RIPPLE   = 1;

   // Meaning of {extra bit, result sign bit}
   typedef enum logic [1:0] {
      SOX_FIT_POS = 2'b00,
      SOX_OVER    = 2'b01,
      SOX_UNDER   = 2'b10,
      SOX_FIT_NEG = 2'b11
   } sox_range_e;

endpackage

// File: rtl/sox_sign_ext.sv
module sox_sign_ext #(
   parameter int WIDTH = 4,
   localparam int EW   = WIDTH + 1
) (
   input  logic [WIDTH-1:0] din,
   output logic [EW-1:0]    dout
);
   // Repeat the sign bit once above the operand
   assign dout = {din[WIDTH-1], din};
endmodule

// File: rtl/sox_sum_core.sv
module sox_sum_core
   import sox_pkg::*;
#(
   parameter int EW   = 5,
   parameter int ARCH = SOX_ARCH_OPERATOR
) (
   input  logic [EW-1:0] x,
   input  logic [EW-1:0] y,
   output logic [EW-1:0] s
);
   generate
      if (ARCH == SOX_ARCH_OPERATOR) begin : g_operator
         assign s = x + y;
      end else if (ARCH == SOX_ARCH_RIPPLE) begin : g_ripple
         logic [EW-1:0] carry;
         assign carry[0] = 1'b0;
         for (genvar i = 0; i < EW; i++) begin : g_bit
            logic half;
            assign half = x[i] ^ y[i];
            assign s[i] = half ^ carry[i];
            if (i < EW - 1) begin : g_carry
               assign carry[i+1] = (x[i] & y[i]) | (carry[i] & half);
            end
         end
      end else begin : g_bad_arch
         $error("sox_sum_core: unsupported ARCH %0d", ARCH);
         assign s = '0;
      end
   endgenerate
endmodule

// File: rtl/sox_flag_decode.sv
module sox_flag_decode
   import sox_pkg::*;
(
   input  logic extra,
   input  logic res_msb,
   output logic overflow,
   output logic underflow
);
   sox_range_e range;

   assign range = sox_range_e'({extra, res_msb});

   always_comb begin
      overflow  = 1'b0;
      underflow = 1'b0;
      case (range)
         SOX_OVER:  overflow  = 1'b1;
         SOX_UNDER: underflow = 1'b1;
         default: ;
      endcase
   end
endmodule

// File: rtl/signed_ovf_adder.sv
module signed_ovf_adder
   import sox_pkg::*;
#(
   parameter int WIDTH = 4,
   parameter int ARCH  = SOX_ARCH_OPERATOR
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] result,
   output logic             overflow,
   output logic             underflow
);
   localparam int EW  = WIDTH + 1;
   localparam int MSB = WIDTH - 1;

   // R9: the smallest legal width holds a sign bit and one magnitude bit
   generate
      if (WIDTH < 2) begin : g_width_chk
         $error("signed_ovf_adder: WIDTH must be at least 2, got %0d", WIDTH);
      end
   endgenerate

   logic [EW-1:0] a_ext;
   logic [EW-1:0] b_ext;
   logic [EW-1:0] sum_ext;

   sox_sign_ext #(.WIDTH(WIDTH)) u_ext_a (.din(a), .dout(a_ext));
   sox_sign_ext #(.WIDTH(WIDTH)) u_ext_b (.din(b), .dout(b_ext));

   sox_sum_core #(.EW(EW), .ARCH(ARCH)) u_core (
      .x (a_ext),
      .y (b_ext),
      .s (sum_ext)
   );

   assign result = sum_ext[MSB:0];

   sox_flag_decode u_flags (
      .extra     (sum_ext[EW-1]),
      .res_msb   (sum_ext[MSB]),
      .overflow  (overflow),
      .underflow (underflow)
   );
endmodule

// File: rtl/signed_ovf_adder_chk.sv
module signed_ovf_adder_chk #(
   parameter int WIDTH = 4
) (
   input logic [WIDTH-1:0] a,
   input logic [WIDTH-1:0] b,
   input logic [WIDTH-1:0] result,
   input logic             overflow,
   input logic             underflow
);
   localparam int MSB = WIDTH - 1;

   always_comb begin
      // R1: low bits wrap modulo 2^WIDTH
      a_r1_wrap_sum: assert (result == WIDTH'(a + b))
         else $error("R1 wrap mismatch");
      // R4: flags exclusive
      a_r4_no_both: assert (!(overflow && underflow))
         else $error("R4 both flags");
      // R2: positive flag only from two non-negative operands with a negative-looking result
      a_r2_ovf_signs: assert (!overflow || (!a[MSB] && !b[MSB] && result[MSB]))
         else $error("R2 overflow sign pattern");
      // R3: negative flag only from two negative operands with a non-negative result
      a_r3_unf_signs: assert (!underflow || (a[MSB] && b[MSB] && !result[MSB]))
         else $error("R3 underflow sign pattern");
      // R8: mixed signs never flag
      a_r8_mixed_quiet: assert ((a[MSB] == b[MSB]) || (!overflow && !underflow))
         else $error("R8 mixed-sign flag");
   end
endmodule

bind signed_ovf_adder signed_ovf_adder_chk #(.WIDTH(WIDTH)) u_chk (
   .a         (a),
   .b         (b),
   .result    (result),
   .overflow  (overflow),
   .underflow (underflow)
);

// File: tb/signed_ovf_adder_test.sv
`timescale 1ns/1ps
module signed_ovf_adder_test;
   logic clk = 1'b0;
   always #5 clk = ~clk;   // 100 MHz

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   logic [3:0] a4, b4, r4;
   logic       ov4, un4;
   logic [7:0] a8, b8, r8;
   logic       ov8, un8;

   signed_ovf_adder uut (
      .a(a4), .b(b4), .result(r4), .overflow(ov4), .underflow(un4)
   );

   signed_ovf_adder #(.WIDTH(8), .ARCH(1)) uut_rc (
      .a(a8), .b(b8), .result(r8), .overflow(ov8), .underflow(un8)
   );

   function automatic int sval(input logic [7:0] v, input int w);
      int u = int'(v) & ((1 << w) - 1);
      return (u >= (1 << (w - 1))) ? u - (1 << w) : u;
   endfunction

   function automatic logic [7:0] exp_res(input int s, input int w);
      return 8'(s & ((1 << w) - 1));
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // full compare of one pair; w selects which instance
   task automatic apply(input int w, input logic [7:0] av, input logic [7:0] bv, input string tag);
      int s;
      @(posedge clk);
      if (w == 4) begin a4 = av[3:0]; b4 = bv[3:0]; end
      else        begin a8 = av;      b8 = bv;      end
      @(negedge clk);
      s = sval(av, w) + sval(bv, w);
      if (w == 4) begin
         chk({tag, " R1 result"}, {4'h0, r4}, exp_res(s, 4));
         chk({tag, " R2 overflow"}, {7'h0, ov4}, {7'h0, s > 7});
         chk({tag, " R3 underflow"}, {7'h0, un4}, {7'h0, s < -8});
         chk({tag, " R4 exclusive"}, {7'h0, ov4 & un4}, 8'h0);
      end else begin
         chk({tag, " R10 R1 result"}, r8, exp_res(s, 8));
         chk({tag, " R10 R2 overflow"}, {7'h0, ov8}, {7'h0, s > 127});
         chk({tag, " R10 R3 underflow"}, {7'h0, un8}, {7'h0, s < -128});
      end
   endtask

   initial begin
      void'($urandom(32'd20240613));
      a4 = '0; b4 = '0; a8 = '0; b8 = '0;
      @(negedge clk);
      // initial state: zero inputs give zero and no flags
      chk("R9 zero result", {4'h0, r4}, 8'h0);
      chk("R9 zero flags", {6'h0, ov4, un4}, 8'h0);

      // R9: outputs move without any clock edge
      a4 = 4'd5; b4 = 4'd2;
      #1;
      chk("R9 no-clock result", {4'h0, r4}, 8'h07);

      // R5 / R6 / R7 directed
      apply(4, 8'h07, 8'h01, "R5 +7+1");
      chk("R5 pattern", {4'h0, r4, 2'b00, ov4, un4}, {4'h0, 4'b1000, 4'b0010});
      apply(4, 8'h08, 8'h0F, "R6 -8+-1");
      chk("R6 pattern", {4'h0, r4, 2'b00, ov4, un4}, {4'h0, 4'b0111, 4'b0001});
      apply(4, 8'h03, 8'h03, "R7 3+3");
      chk("R7 +6", {r4, 2'b00, ov4, un4}, {4'b0110, 4'b0000});
      apply(4, 8'h0D, 8'h0D, "R7 -3+-3");
      chk("R7 -6", {r4, 2'b00, ov4, un4}, {4'b1010, 4'b0000});

      // exhaustive sweep at WIDTH=4
      for (int i = 0; i < 16; i++) begin
         for (int j = 0; j < 16; j++) begin
            apply(4, 8'(i), 8'(j), "sweep");
            if (i[3] != j[3])
               chk("R8 mixed-sign flags", {6'h0, ov4, un4}, 8'h0);
         end
      end

      // ripple variant at WIDTH=8
      apply(8, 8'h7F, 8'h01, "R10 127+1");
      apply(8, 8'h80, 8'hFF, "R10 -128+-1");
      apply(8, 8'h80, 8'h80, "R10 -128+-128");
      apply(8, 8'h7F, 8'h7F, "R10 127+127");
      apply(8, 8'h7F, 8'h80, "R10 127+-128");
      for (int k = 0; k < 2000; k++)
         apply(8, 8'($urandom), 8'($urandom), "R10 random");

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end
endmodule